// File: doc/BRIEF.md
# Multi-Width Signed Integer Divider

This block divides a signed dividend of twice the operand width by a signed divisor of operand width. It produces a quotient and a remainder, each of operand width. A two-bit size select chooses the operand width: 8, 16, 32 or 64 bits. For 16, 32 and 64 bits the dividend is formed from two inputs, an upper half and a lower half, each of operand width. For 8 bits the dividend is the 16-bit value in the low bits of the lower-half input.

The divider is sequential. It works on magnitudes, one quotient bit per clock, and applies the signs at the end. The quotient is truncated toward zero, and the remainder takes the sign of the dividend. A divide-error output reports two cases: a zero divisor, and a quotient outside the signed range of the operand width. When it reports an error, the result outputs keep their earlier contents.

A caller pulses `start` while `busy` is low and then waits for the one-cycle `done` pulse. Results are presented sign-extended to 64 bits.

Top module: `sdiv_multi`

## Requirements
- R1: `size_sel` codes are 0 for 8 bits, 1 for 16 bits, 2 for 32 bits and 3 for 64 bits. In 8-bit mode the dividend is `dvd_lo[15:0]` and `dvd_hi` is ignored. In the other modes the dividend is {`dvd_hi[W-1:0]`, `dvd_lo[W-1:0]`}. Only `divisor[W-1:0]` is used, and all input bits above these fields have no effect.
- R2: When there is no error, `quot` is the true quotient truncated toward zero and sign-extended to 64 bits.
- R3: When there is no error, `rem` equals dividend minus quotient times divisor, sign-extended to 64 bits. It is zero or has the sign of the dividend, and its magnitude is below the divisor's magnitude.
- R4: A zero divisor field raises `div_err` together with `done`, and `done` rises one cycle after acceptance.
- R5: `div_err` is raised with `done` when the quotient is above 2^(W-1)-1 or below -2^(W-1).
- R6: When `div_err` is raised, `quot` and `rem` keep the values of the last error-free result.
- R7: For a nonzero divisor, `done` is a single-cycle pulse 2W+1 cycles after the accepting edge. `busy` is high from acceptance until `done`, and `busy` is never high in the cycle `done` is high.
- R8: `start` is accepted only while `busy` is low. Operands are sampled on the accepting edge, so later changes to the inputs, or a `start` pulse while busy, do not alter the result or its timing.
- R9: After reset `busy`, `done`, `div_err`, `quot` and `rem` are all zero.
- R10: A quotient exactly equal to -2^(W-1) is valid and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a division; taken when busy is low |
| size_sel | input | 2 | Operand width code (0:8, 1:16, 2:32, 3:64) |
| dvd_hi | input | 64 | Upper half of the dividend |
| dvd_lo | input | 64 | Lower half of the dividend (whole 16-bit dividend in 8-bit mode) |
| divisor | input | 64 | Divisor, low W bits used |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Error status of the last completed operation |
| quot | output | 64 | Quotient, sign-extended |
| rem | output | 64 | Remainder, sign-extended |

## Verification
Some rules are checked on every cycle. These are the shape of the handshake, the latency from acceptance to `done` for each width, a raised error for every zero divisor, result outputs that hold when an error is reported, and the bound and sign of the remainder. The numeric value of the quotient cannot be checked that way, and neither can the exact overflow boundaries or the ignored input bits. Those depend on the bench's directed cases and its reference division over random and constructed operands. So do the effects of start pulses and input changes during a busy interval.

// File: rtl/sdiv_pkg.sv
// Package for the multi-width signed divider.
// Holds the operand size codes, the control phases and the widest operand width.
// Assumes the widest operand width is 64 bits, since the four size codes are fixed.
package sdiv_pkg;
    localparam int unsigned MAX_W = 64;
    localparam int unsigned DBL_W = 2 * MAX_W;
    localparam int unsigned CNT_W = $clog2(DBL_W + 1);

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } opsize_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_WB   = 2'd2
    } phase_e;
endpackage

// File: rtl/sdiv_prep.sv
// Operand preparation.
// Builds the sign-extended dividend and divisor for the selected width and takes their
// signs and magnitudes. It left-aligns the dividend magnitude so the shift core always
// starts from the top bit, and it gives the number of steps (twice the width).
// Assumes MAX_W is 64. Purely combinational.
module sdiv_prep
    import sdiv_pkg::*;
(
    input  opsize_e            size,
    input  logic [MAX_W-1:0]   hi,
    input  logic [MAX_W-1:0]   lo,
    input  logic [MAX_W-1:0]   dvs,
    output logic               dvd_neg,
    output logic               dvs_neg,
    output logic               dvs_zero,
    output logic [DBL_W-1:0]   dvd_aligned,
    output logic [MAX_W-1:0]   dvs_mag,
    output logic [CNT_W-1:0]   steps
);
    localparam int unsigned SH_8  = DBL_W - 16;
    localparam int unsigned SH_16 = DBL_W - 32;
    localparam int unsigned SH_32 = DBL_W - 64;

    logic [DBL_W-1:0] dvd_ext;
    logic [MAX_W-1:0] dvs_ext;
    logic [DBL_W-1:0] dvd_mag;
    logic [6:0]       shamt;

    // Widen dividend and divisor from the selected width, and pick the alignment and step count.
    always_comb begin
        unique case (size)
            SZ_8: begin
                dvd_ext = {{(DBL_W-16){lo[15]}}, lo[15:0]};
                dvs_ext = {{(MAX_W-8){dvs[7]}}, dvs[7:0]};
                shamt   = 7'(SH_8);
                steps   = CNT_W'(16);
            end
            SZ_16: begin
                dvd_ext = {{(DBL_W-32){hi[15]}}, hi[15:0], lo[15:0]};
                dvs_ext = {{(MAX_W-16){dvs[15]}}, dvs[15:0]};
                shamt   = 7'(SH_16);
                steps   = CNT_W'(32);
            end
            SZ_32: begin
                dvd_ext = {{(DBL_W-64){hi[31]}}, hi[31:0], lo[31:0]};
                dvs_ext = {{(MAX_W-32){dvs[31]}}, dvs[31:0]};
                shamt   = 7'(SH_32);
                steps   = CNT_W'(64);
            end
            default: begin
                dvd_ext = {hi, lo};
                dvs_ext = dvs;
                shamt   = 7'd0;
                steps   = CNT_W'(DBL_W);
            end
        endcase
    end

    // Signs, magnitudes and the left-aligned dividend.
    always_comb begin
        dvd_neg     = dvd_ext[DBL_W-1];
        dvs_neg     = dvs_ext[MAX_W-1];
        dvs_zero    = (dvs_ext == '0);
        dvd_mag     = dvd_neg ? (~dvd_ext + 1'b1) : dvd_ext;
        dvs_mag     = dvs_neg ? (~dvs_ext + 1'b1) : dvs_ext;
        dvd_aligned = dvd_mag << shamt;
    end
endmodule

// File: rtl/sdiv_core.sv
// Restoring divide core on unsigned magnitudes.
// Each active cycle shifts one dividend bit into the partial remainder, tries a subtract,
// and shifts the resulting quotient bit in at the bottom. After `steps` cycles the quotient
// magnitude fills the double-width register and the partial remainder is the remainder.
// Assumes the divisor is nonzero, and that the dividend is left-aligned so the first step
// sees its top bit.
module sdiv_core
    import sdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [DBL_W-1:0]   dvd_aligned,
    input  logic [MAX_W-1:0]   dvs_mag,
    input  logic [CNT_W-1:0]   steps,
    output logic               last,
    output logic [DBL_W-1:0]   quo_mag,
    output logic [MAX_W-1:0]   rem_mag
);
    logic [MAX_W-1:0] part_q;
    logic [DBL_W-1:0] acc_q;
    logic [MAX_W-1:0] dsr_q;
    logic [CNT_W-1:0] cnt_q;

    logic [MAX_W:0]   shifted;
    logic [MAX_W+1:0] trial;
    logic             fits;
    logic             active;

    // One trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        shifted = {part_q, acc_q[DBL_W-1]};
        trial   = {1'b0, shifted} - {2'b00, dsr_q};
        fits    = ~trial[MAX_W+1];
        active  = (cnt_q != '0);
        last    = (cnt_q == CNT_W'(1));
    end

    // Load the operands or advance one step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_q <= '0;
            acc_q  <= '0;
            dsr_q  <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            part_q <= '0;
            acc_q  <= dvd_aligned;
            dsr_q  <= dvs_mag;
            cnt_q  <= steps;
        end else if (active) begin
            part_q <= fits ? trial[MAX_W-1:0] : shifted[MAX_W-1:0];
            acc_q  <= {acc_q[DBL_W-2:0], fits};
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign quo_mag = acc_q;
    assign rem_mag = part_q;
endmodule

// File: rtl/sdiv_fixup.sv
// Sign fix-up and range check.
// Applies the result signs to the magnitude quotient and remainder. It flags overflow when
// the double-width quotient magnitude is outside the signed range of the selected width:
// up to 2^(W-1) is allowed for a negative result, and up to 2^(W-1)-1 for a positive one.
// Purely combinational. Assumes the remainder magnitude is below the divisor magnitude.
module sdiv_fixup
    import sdiv_pkg::*;
(
    input  opsize_e            size,
    input  logic               q_neg,
    input  logic               r_neg,
    input  logic [DBL_W-1:0]   quo_mag,
    input  logic [MAX_W-1:0]   rem_mag,
    output logic [MAX_W-1:0]   quot,
    output logic [MAX_W-1:0]   rem,
    output logic               ovf
);
    logic [DBL_W-1:0] limit;
    logic [DBL_W-1:0] q_signed;

    // Magnitude of the most negative value for the selected width.
    always_comb begin
        unique case (size)
            SZ_8:    limit = DBL_W'(1) << 7;
            SZ_16:   limit = DBL_W'(1) << 15;
            SZ_32:   limit = DBL_W'(1) << 31;
            default: limit = DBL_W'(1) << (MAX_W - 1);
        endcase
    end

    // Range check on the full magnitude, then apply the signs.
    always_comb begin
        ovf      = q_neg ? (quo_mag > limit) : (quo_mag >= limit);
        q_signed = q_neg ? (~quo_mag + 1'b1) : quo_mag;
        quot     = q_signed[MAX_W-1:0];
        rem      = r_neg ? (~rem_mag + 1'b1) : rem_mag;
    end
endmodule

// File: rtl/sdiv_multi.sv
// Multi-width signed divider, top level.
// Accepts a request while idle, samples the operands and signs, and runs the divide core
// for twice the operand width. It then writes back a sign-corrected result or raises the
// error output. A zero divisor skips the core and completes on the next cycle.
// Assumes synchronous active-low reset and a single clock.
module sdiv_multi
    import sdiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [1:0]  size_sel,
    input  logic [63:0] dvd_hi,
    input  logic [63:0] dvd_lo,
    input  logic [63:0] divisor,
    output logic        busy,
    output logic        done,
    output logic        div_err,
    output logic [63:0] quot,
    output logic [63:0] rem
);
    phase_e           phase_q;
    opsize_e          size_q;
    logic             qneg_q;
    logic             rneg_q;
    logic             zero_q;
    logic             done_q;
    logic             err_q;
    logic [MAX_W-1:0] quot_q;
    logic [MAX_W-1:0] rem_q;

    opsize_e          size_in;
    logic             accept;
    logic             p_dvd_neg;
    logic             p_dvs_neg;
    logic             p_dvs_zero;
    logic [DBL_W-1:0] p_dvd_al;
    logic [MAX_W-1:0] p_dvs_mag;
    logic [CNT_W-1:0] p_steps;
    logic             c_last;
    logic [DBL_W-1:0] c_quo;
    logic [MAX_W-1:0] c_rem;
    logic [MAX_W-1:0] f_quot;
    logic [MAX_W-1:0] f_rem;
    logic             f_ovf;
    logic             wb_err;

    // Decode the request.
    always_comb begin
        size_in = opsize_e'(size_sel);
        accept  = start && (phase_q == PH_IDLE);
        wb_err  = zero_q || f_ovf;
    end

    sdiv_prep u_prep (
        .size        (size_in),
        .hi          (dvd_hi),
        .lo          (dvd_lo),
        .dvs         (divisor),
        .dvd_neg     (p_dvd_neg),
        .dvs_neg     (p_dvs_neg),
        .dvs_zero    (p_dvs_zero),
        .dvd_aligned (p_dvd_al),
        .dvs_mag     (p_dvs_mag),
        .steps       (p_steps)
    );

    sdiv_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept && !p_dvs_zero),
        .dvd_aligned (p_dvd_al),
        .dvs_mag     (p_dvs_mag),
        .steps       (p_steps),
        .last        (c_last),
        .quo_mag     (c_quo),
        .rem_mag     (c_rem)
    );

    sdiv_fixup u_fix (
        .size    (size_q),
        .q_neg   (qneg_q),
        .r_neg   (rneg_q),
        .quo_mag (c_quo),
        .rem_mag (c_rem),
        .quot    (f_quot),
        .rem     (f_rem),
        .ovf     (f_ovf)
    );

    // Control sequence: accept, iterate, write back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            size_q  <= SZ_8;
            qneg_q  <= 1'b0;
            rneg_q  <= 1'b0;
            zero_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            quot_q  <= '0;
            rem_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        size_q  <= size_in;
                        qneg_q  <= p_dvd_neg ^ p_dvs_neg;
                        rneg_q  <= p_dvd_neg;
                        zero_q  <= p_dvs_zero;
                        phase_q <= p_dvs_zero ? PH_WB : PH_RUN;
                    end
                end
                PH_RUN: begin
                    if (c_last) phase_q <= PH_WB;
                end
                default: begin
                    done_q  <= 1'b1;
                    err_q   <= wb_err;
                    if (!wb_err) begin
                        quot_q <= f_quot;
                        rem_q  <= f_rem;
                    end
                    phase_q <= PH_IDLE;
                end
            endcase
        end
    end

    assign busy    = (phase_q != PH_IDLE);
    assign done    = done_q;
    assign div_err = err_q;
    assign quot    = quot_q;
    assign rem     = rem_q;
endmodule

// File: rtl/sdiv_multi_chk.sv
// Protocol and result checker for sdiv_multi, attached by bind.
// It keeps its own copy of the accepted size, divisor and dividend sign, plus a cycle count
// since acceptance. From these it checks the handshake, the latency, the error cases and
// the remainder bound at the ports.
module sdiv_multi_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [1:0]  size_sel,
    input logic [63:0] dvd_hi,
    input logic [63:0] dvd_lo,
    input logic [63:0] divisor,
    input logic        busy,
    input logic        done,
    input logic        div_err,
    input logic [63:0] quot,
    input logic [63:0] rem
);
    logic [1:0]  cap_size;
    logic        cap_zero;
    logic        cap_dneg;
    logic [63:0] cap_dmag;
    logic [7:0]  lat;
    logic [63:0] dvs_x;
    logic        dneg_x;
    logic [63:0] rem_abs;
    logic [7:0]  exp_lat;

    // Widen the current divisor and take the dividend sign for the size on the inputs.
    always_comb begin
        unique case (size_sel)
            2'd0: begin dvs_x = {{56{divisor[7]}},  divisor[7:0]};  dneg_x = dvd_lo[15]; end
            2'd1: begin dvs_x = {{48{divisor[15]}}, divisor[15:0]}; dneg_x = dvd_hi[15]; end
            2'd2: begin dvs_x = {{32{divisor[31]}}, divisor[31:0]}; dneg_x = dvd_hi[31]; end
            default: begin dvs_x = divisor; dneg_x = dvd_hi[63]; end
        endcase
        rem_abs = rem[63] ? (~rem + 1'b1) : rem;
        exp_lat = cap_zero ? 8'd1 : (8'(8) << cap_size) * 8'd2 + 8'd1;
    end

    // Capture the accepted operands and count cycles since acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_size <= 2'd0;
            cap_zero <= 1'b0;
            cap_dneg <= 1'b0;
            cap_dmag <= '0;
            lat      <= '0;
        end else if (start && !busy) begin
            cap_size <= size_sel;
            cap_zero <= (dvs_x == '0);
            cap_dneg <= dneg_x;
            cap_dmag <= dvs_x[63] ? (~dvs_x + 1'b1) : dvs_x;
            lat      <= '0;
        end else if (lat != 8'hFF) begin
            lat <= lat + 1'b1;
        end
    end

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_not_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_busy_ends_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat == exp_lat));

    assert_zero_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_zero) |-> div_err);

    assert_err_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_err) |-> ($stable(quot) && $stable(rem)));

    assert_rem_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_err) |-> (rem_abs < cap_dmag));

    assert_rem_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_err && (rem != '0)) |-> (rem[63] == cap_dneg));
endmodule

bind sdiv_multi sdiv_multi_chk u_sdiv_multi_chk (.*);

// File: tb/test_sdiv_multi.sv
`timescale 1ns/1ps
module test_sdiv_multi;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  size_sel = 2'd0;
    logic [63:0] dvd_hi = '0;
    logic [63:0] dvd_lo = '0;
    logic [63:0] divisor = '0;
    logic        busy, done, div_err;
    logic [63:0] quot, rem;

    int nchk = 0;
    int nerr = 0;
    logic [63:0] prev_q = '0;
    logic [63:0] prev_r = '0;

    always #2.5 clk = ~clk;

    sdiv_multi i_sdiv_multi (
        .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
        .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor),
        .busy(busy), .done(done), .div_err(div_err), .quot(quot), .rem(rem)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic signed [127:0] sx(input logic [63:0] x, input int w);
        logic signed [127:0] r;
        r = '0;
        for (int i = 0; i < 128; i++) r[i] = (i < w) ? x[i] : x[w-1];
        return r;
    endfunction

    // Reference: dividend formation (R1), truncating division, range rules (R4, R5).
    task automatic model(input logic [1:0] sz, input logic [63:0] hi, input logic [63:0] lo,
                         input logic [63:0] dv, output bit err, output bit zero,
                         output logic [63:0] q, output logic [63:0] r);
        int w;
        logic signed [127:0] a, b, qq, rr, one, maxp, minn;
        w = 8 << sz;
        if (sz == 2'd0) a = sx(lo, 16);
        else a = (sx(hi, w) <<< w) | ($signed({64'd0, lo}) & ((128'sd1 <<< w) - 1));
        b = sx(dv, w);
        one = 128'sd1;
        maxp = (one <<< (w - 1)) - 1;
        minn = -(one <<< (w - 1));
        zero = (b == 0);
        q = '0; r = '0;
        if (zero) err = 1'b1;
        else begin
            qq = a / b;
            rr = a % b;
            err = (qq > maxp) || (qq < minn);
            q = qq[63:0];
            r = rr[63:0];
        end
    endtask

    task automatic run_op(input logic [1:0] sz, input logic [63:0] hi, input logic [63:0] lo,
                          input logic [63:0] dv, input string qtag, input bit poke);
        bit eerr, ezero;
        logic [63:0] eq, er;
        int k, elat;
        model(sz, hi, lo, dv, eerr, ezero, eq, er);
        elat = ezero ? 1 : 2 * (8 << sz) + 1;
        @(negedge clk);
        size_sel = sz; dvd_hi = hi; dvd_lo = lo; divisor = dv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dvd_hi = {$urandom, $urandom}; dvd_lo = {$urandom, $urandom};
        divisor = {$urandom, $urandom}; size_sel = 2'($urandom);
        k = 0;
        while (!done && k < 400) begin
            @(negedge clk);
            k++;
            if (!done && poke && k == 3) begin
                start = 1'b1;
                dvd_hi = {$urandom, $urandom}; dvd_lo = {$urandom, $urandom};
                divisor = 64'd0;
            end else start = 1'b0;
        end
        start = 1'b0;
        chk(k == elat, poke ? "R8 latency" : (ezero ? "R4 latency" : "R7 latency"), 64'(k), 64'(elat));
        chk(!busy, "R7 busy at done", {63'd0, busy}, 64'd0);
        chk(div_err == eerr, ezero ? "R4 error" : (poke ? "R8 error" : "R5 error"), {63'd0, div_err}, {63'd0, eerr});
        if (eerr) begin
            chk(quot == prev_q, "R6 quot hold", quot, prev_q);
            chk(rem == prev_r, "R6 rem hold", rem, prev_r);
        end else begin
            chk(quot == eq, qtag, quot, eq);
            chk(rem == er, "R3 remainder", rem, er);
            prev_q = eq;
            prev_r = er;
        end
    endtask

    // Builds an operand set whose quotient is in range: dividend = q*d + r.
    task automatic run_fit(input logic [1:0] sz);
        int w;
        logic signed [127:0] d, q, p, rr, a;
        logic [127:0] dmag;
        logic [63:0] rm, hi, lo;
        w = 8 << sz;
        do d = sx({$urandom, $urandom} >> ($urandom % w), w); while (d == 0);
        q = sx({$urandom, $urandom} >> ($urandom % w), w);
        p = q * d;
        dmag = (d < 0) ? -d : d;
        rm = {$urandom, $urandom} % dmag[63:0];
        rr = $signed({64'd0, rm});
        if (p < 0 || (p == 0 && $urandom % 2 == 1)) rr = -rr;
        a = p + rr;
        lo = a[63:0];
        hi = 64'(a >>> w);
        if (sz == 2'd0) begin
            lo = {$urandom, $urandom[15:0], a[15:0]};
            hi = {$urandom, $urandom};
        end
        run_op(sz, hi, lo, d[63:0], "R2 quotient", 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !div_err, "R9 reset flags", {61'd0, busy, done, div_err}, 64'd0);
        chk(quot == 0 && rem == 0, "R9 reset results", quot | rem, 64'd0);

        // R1: 8-bit uses dvd_lo[15:0] only; upper bits are noise.
        run_op(2'd0, 64'hA5A5_1234_5678_9ABC, 64'hDEAD_BEEF_CAFE_0064, 64'hFFFF_FF00_0000_1207, "R1 8-bit", 1'b0);
        run_op(2'd0, 64'h0, 64'h0000_0000_0000_FF9C, 64'h7, "R2 negative dividend", 1'b0);
        run_op(2'd0, 64'h0, 64'h0000_0000_0000_0064, 64'hF9, "R2 negative divisor", 1'b0);
        run_op(2'd0, 64'h0, 64'h0000_0000_0000_FF00, 64'h2, "R10 min quotient 8", 1'b0);
        run_op(2'd0, 64'h0, 64'h0000_0000_0000_0100, 64'h2, "R5", 1'b0);
        run_op(2'd0, 64'h0, 64'h0000_0000_0000_8000, 64'hFF, "R5", 1'b0);
        run_op(2'd1, 64'h0, 64'h1234, 64'hFFFF_0000, "R4", 1'b0);
        run_op(2'd1, 64'hFFFF_FFFF_FFFF_0001, 64'h7777_0000_0000_0000, 64'h3, "R1 16-bit", 1'b0);
        run_op(2'd2, 64'hFFFF_FFFF, 64'h0000_0001_8000_0000, 64'h1_0000_0001, "R1 32-bit", 1'b0);
        run_op(2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h2, "R10 min quotient 64", 1'b0);
        run_op(2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'hFFFF_FFFF_FFFF_FFFE, "R5", 1'b0);
        run_op(2'd3, 64'h8000_0000_0000_0000, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R5", 1'b0);
        run_op(2'd3, 64'h0, 64'h0, 64'h0, "R4", 1'b0);
        run_op(2'd1, 64'h0, 64'h0000_0000_0000_7FFF, 64'h5, "R8 start while busy", 1'b1);
        run_op(2'd2, 64'hFFFF_FFFF, 64'hFFFF_FFF9, 64'h2, "R2 truncation", 1'b0);

        for (int n = 0; n < 240; n++) begin
            logic [1:0] sz;
            sz = 2'($urandom);
            if (n % 3 == 0) run_op(sz, {$urandom, $urandom}, {$urandom, $urandom},
                                   {$urandom, $urandom} >> ($urandom % 64), "R2 random", 1'b0);
            else run_fit(sz);
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule